// File: doc/BRIEF.md
# Key-Guarded Configuration Watchdog

This block is a countdown watchdog whose control registers sit behind a pair of I/O ports: one port holds a register index and the other carries that register's data. The space stays closed until the host writes the unlock key twice back to back at the index port. The host then points the page-select register at the watchdog page. From there it can set the enable bit, pick seconds or minutes as the count unit, load the 8-bit countdown, and allow keyboard or mouse interrupt events to reload the timer. Writing the lock key at the index port closes the space again.

Once enabled with a nonzero count, the block takes one count off per unit. The units come from an internal clock divider with a parameter for its length. When the count runs out, `wdt_reset` is driven high for a fixed number of cycles. A software keepalive is a rewrite of the countdown register. An enabled interrupt source can also reload the countdown in hardware, with no bus traffic.

Top module: `cfgport_watchdog`

## Requirements
- R1: After reset the space is locked and `wdt_reset` is low. Reads of the index port (0x2E) and of the data port (0x2F) return 0xFF.
- R2: The space opens only when 0x87 is written to the index port on two index writes in a row. Any other index value written between them sends the sequence back to locked. While the space is closed, reads still return 0xFF.
- R3: While unlocked, index 0x07 is the page register, and it can be read and written at the data port. Data-port writes to watchdog registers take effect only when the page register holds 0x08. Any other page value makes such writes have no effect and makes their reads return 0xFF.
- R4: An index write of 0xAA while unlocked closes the space and clears the page register and the index register to 0.
- R5: Register 0x30 bit 0 is the enable. Register 0xF5 bit 3 is the count unit (0 = seconds, 1 = minutes). Register 0xF7 bit 6 allows keyboard reload and bit 7 allows mouse reload. All other bits of these registers read back as 0.
- R6: A write to register 0xF6 loads both the countdown and the reload value, and it restarts the unit divider. A read of 0xF6 returns the live remaining count, which falls by one per unit while the block is enabled.
- R7: In seconds mode, with the block enabled, loading N ≠ 0 raises `wdt_reset` exactly N·SEC_CYCLES cycles after the clock edge that takes the write.
- R8: In minutes mode, the same load raises `wdt_reset` after N·SEC_CYCLES·MIN_SECS cycles.
- R9: `wdt_reset` stays high for exactly RST_CYCLES cycles. The count is then 0, and the block does not fire again until it is reloaded.
- R10: A one-cycle `kbd_irq` pulse with bit 6 set reloads the count from the last 0xF6 value and restarts the divider. `mouse_irq` does the same with bit 7. When its bit is clear, a pulse leaves the count unchanged.
- R11: Writing 0 to 0xF6 while enabled stops the countdown, and no reset follows.
- R12: Clearing the enable freezes the count at its current value, and no reset follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | I/O address, decoded against the index and data port addresses |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| kbd_irq | input | 1 | Keyboard interrupt event, one pulse per event |
| mouse_irq | input | 1 | Mouse interrupt event, one pulse per event |
| wdt_reset | output | 1 | Reset request, high for RST_CYCLES cycles on expiry |

## Verification
A fault in the key sequencer shows at the ports within one bus access. In that case a read at either port returns 0xFF where a register value was expected, or the reverse. A wrong page or field flop is also seen at once in the read-back value. A fault in the divider or the countdown does not show until expiry. It then appears as `wdt_reset` rising one or more cycles early or late, which the bench pins to the exact cycle. A lost reload also shows only then, as a reset that fires inside a window that should be quiet. The live count read at 0xF6 exposes a wrong decrement partway through a window, rather than only at its end.

// File: rtl/cfgwd_pkg.sv
package cfgwd_pkg;
   localparam int REG_W = 8;
   typedef logic [REG_W-1:0] byte_t;

   typedef enum logic [1:0] {
      KEY_LOCKED = 2'd0,
      KEY_ARMED  = 2'd1,
      KEY_OPEN   = 2'd2
   } key_state_e;

   localparam byte_t UNLOCK_KEY   = 8'h87;
   localparam byte_t LOCK_KEY     = 8'hAA;
   localparam byte_t SEL_PAGE_IDX = 8'h07;
   localparam byte_t WDT_PAGE     = 8'h08;
   localparam byte_t ENABLE_IDX   = 8'h30;
   localparam byte_t MODE_IDX     = 8'hF5;
   localparam byte_t COUNT_IDX    = 8'hF6;
   localparam byte_t RELOAD_IDX   = 8'hF7;
   localparam byte_t IDLE_READ    = 8'hFF;

   localparam int ENABLE_BIT   = 0;
   localparam int UNIT_BIT     = 3;
   localparam int RELOAD_LSB   = 6;   // keyboard at 6, mouse at 7
   localparam int N_RELOAD_SRC = 2;
endpackage

// File: rtl/cfgwd_keyseq.sv
module cfgwd_keyseq
   import cfgwd_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  idx_wr,
   input  byte_t wdata,
   output logic  opened,
   output logic  relock
);
   key_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      relock  = 1'b0;
      if (idx_wr) begin
         unique case (state_q)
            KEY_LOCKED: if (wdata == UNLOCK_KEY) state_d = KEY_ARMED;
            KEY_ARMED:  state_d = (wdata == UNLOCK_KEY) ? KEY_OPEN : KEY_LOCKED;
            KEY_OPEN:   if (wdata == LOCK_KEY) begin
                           state_d = KEY_LOCKED;
                           relock  = 1'b1;
                        end
            default:    state_d = KEY_LOCKED;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= KEY_LOCKED;
      else        state_q <= state_d;
   end

   assign opened = (state_q == KEY_OPEN);
endmodule

// File: rtl/cfgwd_regs.sv
module cfgwd_regs
   import cfgwd_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    opened,
   input  logic                    relock,
   input  logic                    idx_wr,
   input  logic                    dat_wr,
   input  logic                    idx_sel,
   input  logic                    dat_sel,
   input  byte_t                   wdata,
   input  byte_t                   live_count,
   output logic                    enable,
   output logic                    unit_min,
   output logic [N_RELOAD_SRC-1:0] reload_mask,
   output logic                    count_wr,
   output logic                    page_ok,
   output byte_t                   rdata
);
   byte_t index_q, page_q;
   logic  field_wr;

   assign page_ok  = (page_q == WDT_PAGE);
   assign field_wr = dat_wr && opened && page_ok;
   assign count_wr = field_wr && (index_q == COUNT_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index_q <= '0;
         page_q  <= '0;
      end else if (relock) begin
         index_q <= '0;
         page_q  <= '0;
      end else begin
         if (idx_wr && opened) index_q <= wdata;
         if (dat_wr && opened && index_q == SEL_PAGE_IDX) page_q <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable   <= 1'b0;
         unit_min <= 1'b0;
      end else if (field_wr) begin
         if (index_q == ENABLE_IDX) enable   <= wdata[ENABLE_BIT];
         if (index_q == MODE_IDX)   unit_min <= wdata[UNIT_BIT];
      end
   end

   byte_t reload_view;
   for (genvar s = 0; s < N_RELOAD_SRC; s++) begin : g_mask
      always_ff @(posedge clk) begin
         if (!rst_n)
            reload_mask[s] <= 1'b0;
         else if (field_wr && index_q == RELOAD_IDX)
            reload_mask[s] <= wdata[RELOAD_LSB + s];
      end
      assign reload_view[RELOAD_LSB + s] = reload_mask[s];
   end
   assign reload_view[RELOAD_LSB-1:0] = '0;

   always_comb begin
      rdata = IDLE_READ;
      if (idx_sel && opened) begin
         rdata = index_q;
      end else if (dat_sel && opened) begin
         if (index_q == SEL_PAGE_IDX) begin
            rdata = page_q;
         end else if (page_ok) begin
            unique case (index_q)
               ENABLE_IDX: rdata = byte_t'(enable) << ENABLE_BIT;
               MODE_IDX:   rdata = byte_t'(unit_min) << UNIT_BIT;
               COUNT_IDX:  rdata = live_count;
               RELOAD_IDX: rdata = reload_view;
               default:    rdata = IDLE_READ;
            endcase
         end
      end
   end
endmodule

// File: rtl/cfgwd_tick.sv
module cfgwd_tick #(
   parameter int SEC_CYCLES = 50_000_000,
   parameter int MIN_SECS   = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   input  logic unit_min,
   output logic unit_tick
);
   localparam int PW = (SEC_CYCLES > 1) ? $clog2(SEC_CYCLES) : 1;
   localparam logic [PW-1:0] P_LAST = PW'(SEC_CYCLES - 1);

   logic [PW-1:0] presc_q;
   logic          sec_tick, min_tick;

   assign sec_tick = run && !restart && (presc_q == P_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || !run || restart) presc_q <= '0;
      else if (presc_q == P_LAST)    presc_q <= '0;
      else                           presc_q <= presc_q + 1'b1;
   end

   if (MIN_SECS == 1) begin : g_min_direct
      assign min_tick = sec_tick;
   end else begin : g_min_count
      localparam int MW = $clog2(MIN_SECS);
      localparam logic [MW-1:0] M_LAST = MW'(MIN_SECS - 1);
      logic [MW-1:0] secs_q;
      assign min_tick = sec_tick && (secs_q == M_LAST);
      always_ff @(posedge clk) begin
         if (!rst_n || !run || restart) secs_q <= '0;
         else if (sec_tick)             secs_q <= (secs_q == M_LAST) ? '0 : secs_q + 1'b1;
      end
   end

   assign unit_tick = unit_min ? min_tick : sec_tick;
endmodule

// File: rtl/cfgwd_counter.sv
module cfgwd_counter
   import cfgwd_pkg::*;
#(
   parameter int RST_CYCLES = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enable,
   input  logic                    count_wr,
   input  byte_t                   count_wdata,
   input  logic [N_RELOAD_SRC-1:0] irq_evt,
   input  logic [N_RELOAD_SRC-1:0] irq_mask,
   input  logic                    unit_tick,
   output byte_t                   count,
   output logic                    running,
   output logic                    load_any,
   output logic                    wdt_reset
);
   localparam int RW = $clog2(RST_CYCLES + 1);
   localparam logic [RW-1:0] PULSE_LEN = RW'(RST_CYCLES);

   byte_t                   count_q, reload_q;
   logic [N_RELOAD_SRC-1:0] hit;
   logic [RW-1:0]           pulse_q;
   logic                    irq_any, fire;

   for (genvar s = 0; s < N_RELOAD_SRC; s++) begin : g_src
      assign hit[s] = irq_evt[s] & irq_mask[s];
   end

   assign irq_any  = |hit;
   assign load_any = count_wr | irq_any;
   assign running  = enable && (count_q != '0);
   assign fire     = !load_any && running && unit_tick && (count_q == byte_t'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q  <= '0;
         reload_q <= '0;
      end else if (count_wr) begin
         count_q  <= count_wdata;
         reload_q <= count_wdata;
      end else if (irq_any) begin
         count_q  <= reload_q;
      end else if (running && unit_tick) begin
         count_q  <= count_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)             pulse_q <= '0;
      else if (fire)          pulse_q <= PULSE_LEN;
      else if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
   end

   assign count     = count_q;
   assign wdt_reset = (pulse_q != '0);
endmodule

// File: rtl/cfgport_watchdog.sv
module cfgport_watchdog
   import cfgwd_pkg::*;
#(
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] INDEX_PORT = ADDR_W'('h2E),
   parameter logic [ADDR_W-1:0] DATA_PORT  = ADDR_W'('h2F),
   parameter int                SEC_CYCLES = 50_000_000,
   parameter int                MIN_SECS   = 60,
   parameter int                RST_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              kbd_irq,
   input  logic              mouse_irq,
   output logic              wdt_reset
);
   if (SEC_CYCLES < 1) begin : g_bad_sec
      $error("SEC_CYCLES must be at least 1");
   end
   if (MIN_SECS < 1) begin : g_bad_min
      $error("MIN_SECS must be at least 1");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("RST_CYCLES must be at least 1");
   end
   if (INDEX_PORT == DATA_PORT) begin : g_bad_ports
      $error("index and data ports must differ");
   end

   logic idx_sel, dat_sel, idx_wr, dat_wr;
   logic opened, relock, page_ok;
   logic enable, unit_min, count_wr, running, load_any, unit_tick;
   logic [N_RELOAD_SRC-1:0] reload_mask;
   byte_t live_count;

   assign idx_sel = (bus_addr == INDEX_PORT);
   assign dat_sel = (bus_addr == DATA_PORT);
   assign idx_wr  = bus_wr && idx_sel;
   assign dat_wr  = bus_wr && dat_sel;

   cfgwd_keyseq u_keys (
      .clk    (clk),
      .rst_n  (rst_n),
      .idx_wr (idx_wr),
      .wdata  (bus_wdata),
      .opened (opened),
      .relock (relock)
   );

   cfgwd_regs u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .opened      (opened),
      .relock      (relock),
      .idx_wr      (idx_wr),
      .dat_wr      (dat_wr),
      .idx_sel     (idx_sel),
      .dat_sel     (dat_sel),
      .wdata       (bus_wdata),
      .live_count  (live_count),
      .enable      (enable),
      .unit_min    (unit_min),
      .reload_mask (reload_mask),
      .count_wr    (count_wr),
      .page_ok     (page_ok),
      .rdata       (bus_rdata)
   );

   cfgwd_tick #(
      .SEC_CYCLES (SEC_CYCLES),
      .MIN_SECS   (MIN_SECS)
   ) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (running),
      .restart   (load_any),
      .unit_min  (unit_min),
      .unit_tick (unit_tick)
   );

   cfgwd_counter #(
      .RST_CYCLES (RST_CYCLES)
   ) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .count_wr    (count_wr),
      .count_wdata (bus_wdata),
      .irq_evt     ({mouse_irq, kbd_irq}),
      .irq_mask    (reload_mask),
      .unit_tick   (unit_tick),
      .count       (live_count),
      .running     (running),
      .load_any    (load_any),
      .wdt_reset   (wdt_reset)
   );
endmodule

// File: rtl/cfgport_watchdog_chk.sv
module cfgport_watchdog_chk #(
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] INDEX_PORT = ADDR_W'('h2E),
   parameter logic [ADDR_W-1:0] DATA_PORT  = ADDR_W'('h2F)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic              opened,
   input logic              enable,
   input logic              running,
   input logic              load_any,
   input logic [7:0]        live_count,
   input logic              wdt_reset
);
   AST_LOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!opened && bus_addr == DATA_PORT) |-> (bus_rdata == 8'hFF)); // R3

   AST_UNLOCK_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(opened) |-> $past(bus_wr && bus_addr == INDEX_PORT && bus_wdata == 8'h87)); // R2

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !load_any) |=> (live_count == $past(live_count) ||
                                  live_count == $past(live_count) - 8'd1)); // R6

   AST_FIRE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_reset) |-> ($past(live_count) == 8'd1 && $past(enable))); // R7

   AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (live_count == 8'd0 && !load_any) |=> (live_count == 8'd0)); // R11

   AST_DISABLED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !load_any) |=> $stable(live_count)); // R12
endmodule

bind cfgport_watchdog cfgport_watchdog_chk #(
   .ADDR_W     (ADDR_W),
   .INDEX_PORT (INDEX_PORT),
   .DATA_PORT  (DATA_PORT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .opened     (opened),
   .enable     (enable),
   .running    (running),
   .load_any   (load_any),
   .live_count (live_count),
   .wdt_reset  (wdt_reset)
);

// File: tb/cfgport_watchdog_test.sv
module cfgport_watchdog_test;
   localparam int SEC = 10;
   localparam int MINS = 4;
   localparam int RSTC = 4;
   localparam logic [15:0] IDX = 16'h002E;
   localparam logic [15:0] DAT = 16'h002F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        kbd_irq = 1'b0;
   logic        mouse_irq = 1'b0;
   logic        wdt_reset;

   always #10 clk = ~clk;

   cfgport_watchdog #(
      .ADDR_W(16), .INDEX_PORT(IDX), .DATA_PORT(DAT),
      .SEC_CYCLES(SEC), .MIN_SECS(MINS), .RST_CYCLES(RSTC)
   ) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kbd_irq(kbd_irq),
      .mouse_irq(mouse_irq), .wdt_reset(wdt_reset)
   );

   int checks = 0;
   int errors = 0;

   // {req[3:0], write, addr[7:0], data[7:0], expected[7:0]}
   localparam int NV = 41;
   localparam logic [28:0] VEC [NV] = '{
      {4'd1, 1'b0, 8'h2E, 8'h00, 8'hFF},  // R1 index locked
      {4'd1, 1'b0, 8'h2F, 8'h00, 8'hFF},  // R1 data locked
      {4'd2, 1'b1, 8'h2E, 8'h87, 8'h00},  // R2 first key
      {4'd2, 1'b1, 8'h2E, 8'h55, 8'h00},  // R2 breaks sequence
      {4'd2, 1'b1, 8'h2E, 8'h87, 8'h00},  // R2 first key again
      {4'd2, 1'b0, 8'h2E, 8'h00, 8'hFF},  // R2 still closed
      {4'd2, 1'b1, 8'h2E, 8'h87, 8'h00},  // R2 second key opens
      {4'd2, 1'b0, 8'h2E, 8'h00, 8'h00},  // R2 index visible
      {4'd3, 1'b1, 8'h2E, 8'h30, 8'h00},  // R3
      {4'd3, 1'b1, 8'h2F, 8'h01, 8'h00},  // R3 write without page
      {4'd3, 1'b0, 8'h2F, 8'h00, 8'hFF},  // R3 read without page
      {4'd3, 1'b1, 8'h2E, 8'h07, 8'h00},  // R3
      {4'd3, 1'b1, 8'h2F, 8'h08, 8'h00},  // R3 select page
      {4'd3, 1'b0, 8'h2F, 8'h00, 8'h08},  // R3 page reads back
      {4'd3, 1'b1, 8'h2E, 8'h30, 8'h00},  // R3
      {4'd3, 1'b0, 8'h2F, 8'h00, 8'h00},  // R3 earlier write had no effect
      {4'd5, 1'b1, 8'h2F, 8'hFF, 8'h00},  // R5
      {4'd5, 1'b0, 8'h2F, 8'h00, 8'h01},  // R5 enable bit only
      {4'd5, 1'b1, 8'h2F, 8'h00, 8'h00},  // R5
      {4'd5, 1'b1, 8'h2E, 8'hF5, 8'h00},  // R5
      {4'd5, 1'b1, 8'h2F, 8'hFF, 8'h00},  // R5
      {4'd5, 1'b0, 8'h2F, 8'h00, 8'h08},  // R5 unit bit only
      {4'd5, 1'b1, 8'h2F, 8'h00, 8'h00},  // R5
      {4'd5, 1'b1, 8'h2E, 8'hF7, 8'h00},  // R5
      {4'd5, 1'b1, 8'h2F, 8'hFF, 8'h00},  // R5
      {4'd5, 1'b0, 8'h2F, 8'h00, 8'hC0},  // R5 reload bits only
      {4'd5, 1'b1, 8'h2F, 8'h00, 8'h00},  // R5
      {4'd5, 1'b0, 8'h2F, 8'h00, 8'h00},  // R5
      {4'd6, 1'b1, 8'h2E, 8'hF6, 8'h00},  // R6
      {4'd6, 1'b1, 8'h2F, 8'h2A, 8'h00},  // R6 load count
      {4'd6, 1'b0, 8'h2F, 8'h00, 8'h2A},  // R6 count reads back
      {4'd6, 1'b1, 8'h2F, 8'h00, 8'h00},  // R6
      {4'd4, 1'b1, 8'h2E, 8'hAA, 8'h00},  // R4 lock key
      {4'd4, 1'b0, 8'h2F, 8'h00, 8'hFF},  // R4
      {4'd4, 1'b0, 8'h2E, 8'h00, 8'hFF},  // R4
      {4'd4, 1'b1, 8'h2E, 8'h87, 8'h00},  // R4
      {4'd4, 1'b1, 8'h2E, 8'h87, 8'h00},  // R4 reopen
      {4'd4, 1'b1, 8'h2E, 8'h30, 8'h00},  // R4
      {4'd4, 1'b0, 8'h2F, 8'h00, 8'hFF},  // R4 page was cleared
      {4'd4, 1'b1, 8'h2E, 8'h07, 8'h00},  // R4
      {4'd4, 1'b0, 8'h2F, 8'h00, 8'h00}   // R4 page reads 0
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic pulse(input bit mouse);
      if (mouse) mouse_irq = 1'b1; else kbd_irq = 1'b1;
      @(posedge clk);
      @(negedge clk);
      mouse_irq = 1'b0; kbd_irq = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic idle_low(input int n, input string req);
      int hi = 0;
      repeat (n) begin
         @(negedge clk);
         if (wdt_reset) hi++;
      end
      check(req, (hi > 255) ? 8'hFF : 8'(hi), 8'h00);
   endtask

   // low for n-1 cycles, then high on the n-th
   task automatic expect_fire(input int n, input string req);
      idle_low(n - 1, req);
      @(negedge clk);
      check(req, {7'd0, wdt_reset}, 8'h01);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] r;
      logic [28:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1", {7'd0, wdt_reset}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         if (v[24]) wr({8'h00, v[23:16]}, v[15:8]);
         else begin
            rd({8'h00, v[23:16]}, r);
            check($sformatf("R%0d", v[28:25]), r, v[7:0]);
         end
      end

      // R7 seconds-mode expiry, R6 live count, R9 pulse length
      wr(DAT, 8'h08);
      wr(IDX, 8'h30); wr(DAT, 8'h01);
      wr(IDX, 8'hF6); wr(DAT, 8'h03);
      idle(15);
      rd(DAT, r); check("R6", r, 8'h02);
      expect_fire(15, "R7");
      idle(RSTC - 1);
      check("R9", {7'd0, wdt_reset}, 8'h01);
      idle(1);
      check("R9", {7'd0, wdt_reset}, 8'h00);
      idle_low(50, "R9");
      rd(DAT, r); check("R9", r, 8'h00);

      // R8 minutes-mode expiry
      wr(IDX, 8'hF5); wr(DAT, 8'h08);
      wr(IDX, 8'hF6); wr(DAT, 8'h02);
      expect_fire(2 * SEC * MINS, "R8");
      idle(10);
      wr(IDX, 8'hF5); wr(DAT, 8'h00);

      // R11 zero stops the timer
      wr(IDX, 8'hF6); wr(DAT, 8'h05);
      idle(15);
      wr(DAT, 8'h00);
      idle_low(100, "R11");
      rd(DAT, r); check("R11", r, 8'h00);

      // R12 disable freezes the count
      wr(DAT, 8'h05);
      idle(25);
      wr(IDX, 8'h30); wr(DAT, 8'h00);
      idle_low(100, "R12");
      wr(IDX, 8'hF6);
      rd(DAT, r); check("R12", r, 8'h03);

      // R10 interrupt reloads, gated by their bits
      pulse(1'b0); pulse(1'b1);
      rd(DAT, r); check("R10", r, 8'h03);
      wr(IDX, 8'hF7); wr(DAT, 8'h80);
      wr(IDX, 8'hF6);
      pulse(1'b0);
      rd(DAT, r); check("R10", r, 8'h03);
      pulse(1'b1);
      rd(DAT, r); check("R10", r, 8'h05);
      wr(IDX, 8'hF7); wr(DAT, 8'h40);
      wr(IDX, 8'hF6); wr(DAT, 8'h02);
      wr(IDX, 8'h30); wr(DAT, 8'h01);
      idle(15);
      pulse(1'b0);
      expect_fire(2 * SEC, "R10");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule